// File: doc/BRIEF.md
# Physical Register Free List

This block keeps the indices of unused physical registers for a superscalar rename stage in a circular queue. Each cycle it offers up to `ALLOC_W` indices to the rename lanes. It also takes up to `FREE_W` indices released by retirement.

The read position is held twice: as a binary pointer with a wrap bit, and as a one-hot vector. Rename reads use the one-hot vector, so no binary decoder sits on the read path. Released indices are first captured in a staging register together with their count. They reach the queue storage, and the write pointer advances, one cycle later. In that later cycle the staged count is added to the write pointer while the next count is formed.

Allocation in a cycle is permitted only when the committed free count after the previous cycle exceeded `ALLOC_W`. Because of this rule, a staged index that has not yet been written is never read. A recovery input restores the read pointer to a checkpoint, which returns speculatively taken indices to the list.

Top module: `freelist_top`

## Requirements
- R1: After reset the queue is full: `free_count` equals `DEPTH`, `alloc_ok` is 1, and the entry at queue offset i holds index `BASE + i`, so with all lanes requesting lane k is offered `BASE + k`.
- R2: Granted indices go to requesting lanes in lane order. Lane k receives the entry at read pointer plus the number of requesting lanes below k, and lanes without a request consume nothing.
- R3: When `alloc_ok` is 1, the read pointer advances by the number of set bits of `alloc_req`. The next cycle's offers start at the advanced position.
- R4: `alloc_ok` is 1 in a cycle exactly when no redirect is present and, after the previous cycle's updates, the write pointer minus the read pointer exceeded `ALLOC_W`. Indices freed in that previous cycle are not counted.
- R5: Valid freed indices are appended at the write pointer in lane order, skipping invalid lanes. They are offered after all entries queued before them.
- R6: `free_count` is the write pointer plus the staged freed count minus the read pointer. It rises by the number of valid freed lanes one cycle after they are presented.
- R7: With `redirect_valid` high, `alloc_ok` is 0 and the read pointer, in both forms, takes `redirect_head` (binary, wrap bit in the MSB) at the clock edge. Freed indices presented in the same cycle are still accepted.
- R8: `free_count` never exceeds `DEPTH`. No index is offered to a granted lane twice without being freed in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | ALLOC_W | Per-lane allocation request |
| alloc_ok | output | 1 | Requests are granted this cycle |
| alloc_idx | output | ALLOC_W x REG_W | Index offered to each lane |
| free_vld | input | FREE_W | Per-lane release valid |
| free_idx | input | FREE_W x REG_W | Released index per lane |
| redirect_valid | input | 1 | Restore the read pointer, suppress allocation |
| redirect_head | input | PTR_W | Checkpointed read pointer |
| free_count | output | PTR_W | Free entries, including staged releases |

## Verification
Redirect and release can fall in the same cycle. A checkpoint is taken, several cycles of speculative allocation follow, and then a redirect is issued while retirement releases unrelated indices. Recovery is judged correct when `alloc_ok` drops in the redirect cycle and `free_count` reflects both the rewound read pointer and the released indices. The offers that follow must restart at the checkpoint, with the released indices appended behind the reclaimed ones. Allocation and release also coincide throughout the random phase, where the reference model tracks every offered index and flags any index handed out twice.

// File: rtl/fl_pkg.sv
package fl_pkg;

  function automatic logic [5:0] ones32(input logic [31:0] v);
    logic [5:0] n;
    n = '0;
    for (int i = 0; i < 32; i++) n = n + 6'(v[i]);
    return n;
  endfunction

  function automatic logic [5:0] ones_below(input logic [31:0] v, input int k);
    return ones32(v & ((32'd1 << k) - 32'd1));
  endfunction

endpackage

// File: rtl/fl_head.sv
module fl_head #(
  parameter int DEPTH = 32,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] take_cnt,
  input  logic             redirect_valid,
  input  logic [PTR_W-1:0] redirect_head,
  output logic [PTR_W-1:0] head_q,
  output logic [PTR_W-1:0] head_nxt,
  output logic [DEPTH-1:0] head_oh
);
  localparam int IDX_W = PTR_W - 1;

  logic [DEPTH-1:0]   oh_nxt;
  logic [2*DEPTH-1:0] dbl;

  always_comb begin
    dbl = {head_oh, head_oh} << take_cnt;
    if (redirect_valid) begin
      head_nxt = redirect_head;
      oh_nxt   = {{(DEPTH-1){1'b0}}, 1'b1} << redirect_head[IDX_W-1:0];
    end else begin
      head_nxt = head_q + take_cnt;
      oh_nxt   = dbl[2*DEPTH-1:DEPTH];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      head_oh <= {{(DEPTH-1){1'b0}}, 1'b1};
    end else begin
      head_q  <= head_nxt;
      head_oh <= oh_nxt;
    end
  end

  assert_oh_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    head_oh == ({{(DEPTH-1){1'b0}}, 1'b1} << head_q[IDX_W-1:0]));

  assert_redirect_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> head_q == $past(redirect_head));
endmodule

// File: rtl/fl_read.sv
module fl_read #(
  parameter int DEPTH   = 32,
  parameter int REG_W   = 7,
  parameter int ALLOC_W = 4
) (
  input  logic [DEPTH-1:0]              head_oh,
  input  logic [DEPTH-1:0][REG_W-1:0]   store,
  input  logic [ALLOC_W-1:0]            req,
  output logic [ALLOC_W-1:0][REG_W-1:0] lane_idx
);
  import fl_pkg::*;
  localparam int LW = (ALLOC_W > 1) ? $clog2(ALLOC_W) : 1;

  logic [ALLOC_W-1:0][REG_W-1:0] cand;

  for (genvar j = 0; j < ALLOC_W; j++) begin : g_cand
    logic [2*DEPTH-1:0] dbl;
    logic [DEPTH-1:0]   sel;
    always_comb begin
      dbl = {head_oh, head_oh} << j;
      sel = dbl[2*DEPTH-1:DEPTH];
      cand[j] = '0;
      for (int i = 0; i < DEPTH; i++)
        if (sel[i]) cand[j] = cand[j] | store[i];
    end
  end

  for (genvar k = 0; k < ALLOC_W; k++) begin : g_lane
    logic [LW-1:0] pos;
    always_comb begin
      pos         = LW'(ones_below(32'(req), k));
      lane_idx[k] = cand[pos];
    end
  end
endmodule

// File: rtl/fl_tail.sv
module fl_tail #(
  parameter int DEPTH  = 32,
  parameter int REG_W  = 7,
  parameter int FREE_W = 4,
  parameter int BASE   = 32,
  parameter int PTR_W  = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [FREE_W-1:0]             free_vld,
  input  logic [FREE_W-1:0][REG_W-1:0]  free_idx,
  output logic [DEPTH-1:0][REG_W-1:0]   store,
  output logic [PTR_W-1:0]              tail_q,
  output logic [PTR_W-1:0]              pend_cnt_q
);
  import fl_pkg::*;
  localparam int IDX_W = PTR_W - 1;

  logic [FREE_W-1:0]            stg_vld;
  logic [FREE_W-1:0][REG_W-1:0] stg_idx;
  logic [FREE_W-1:0][PTR_W-1:0] waddr;

  always_comb
    for (int k = 0; k < FREE_W; k++)
      waddr[k] = tail_q + PTR_W'(ones_below(32'(stg_vld), k));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_vld    <= '0;
      stg_idx    <= '0;
      pend_cnt_q <= '0;
      tail_q     <= PTR_W'(DEPTH);
      for (int i = 0; i < DEPTH; i++) store[i] <= REG_W'(BASE + i);
    end else begin
      stg_vld    <= free_vld;
      stg_idx    <= free_idx;
      pend_cnt_q <= PTR_W'(ones32(32'(free_vld)));
      tail_q     <= tail_q + pend_cnt_q;
      for (int k = 0; k < FREE_W; k++)
        if (stg_vld[k]) store[waddr[k][IDX_W-1:0]] <= stg_idx[k];
    end
  end

  assert_tail_pipe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tail_q == $past(tail_q) + $past(pend_cnt_q));
endmodule

// File: rtl/freelist_top.sv
module freelist_top #(
  parameter int DEPTH   = 32,
  parameter int REG_W   = 7,
  parameter int ALLOC_W = 4,
  parameter int FREE_W  = 4,
  parameter int BASE    = 32,
  parameter int PTR_W   = $clog2(DEPTH) + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ALLOC_W-1:0]            alloc_req,
  output logic                          alloc_ok,
  output logic [ALLOC_W-1:0][REG_W-1:0] alloc_idx,
  input  logic [FREE_W-1:0]             free_vld,
  input  logic [FREE_W-1:0][REG_W-1:0]  free_idx,
  input  logic                          redirect_valid,
  input  logic [PTR_W-1:0]              redirect_head,
  output logic [PTR_W-1:0]              free_count
);
  import fl_pkg::*;

  logic [PTR_W-1:0]            head_q, head_nxt, tail_q, pend_cnt_q, take_cnt;
  logic [PTR_W-1:0]            count_after;
  logic [DEPTH-1:0]            head_oh;
  logic [DEPTH-1:0][REG_W-1:0] store;
  logic                        can_alloc_q;

  assign alloc_ok    = can_alloc_q & ~redirect_valid;
  assign take_cnt    = alloc_ok ? PTR_W'(ones32(32'(alloc_req))) : '0;
  assign free_count  = tail_q + pend_cnt_q - head_q;
  assign count_after = tail_q + pend_cnt_q - head_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) can_alloc_q <= (DEPTH > ALLOC_W);
    else        can_alloc_q <= count_after > PTR_W'(ALLOC_W);
  end

  fl_head #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_head (
    .clk(clk), .rst_n(rst_n), .take_cnt(take_cnt),
    .redirect_valid(redirect_valid), .redirect_head(redirect_head),
    .head_q(head_q), .head_nxt(head_nxt), .head_oh(head_oh));

  fl_read #(.DEPTH(DEPTH), .REG_W(REG_W), .ALLOC_W(ALLOC_W)) u_read (
    .head_oh(head_oh), .store(store), .req(alloc_req), .lane_idx(alloc_idx));

  fl_tail #(.DEPTH(DEPTH), .REG_W(REG_W), .FREE_W(FREE_W), .BASE(BASE),
            .PTR_W(PTR_W)) u_tail (
    .clk(clk), .rst_n(rst_n), .free_vld(free_vld), .free_idx(free_idx),
    .store(store), .tail_q(tail_q), .pend_cnt_q(pend_cnt_q));

  assert_alloc_safe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    can_alloc_q |-> (PTR_W'(tail_q - head_q) >= PTR_W'(ALLOC_W)));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    free_count <= PTR_W'(DEPTH));
endmodule

// File: tb/tb_freelist_top.sv
`timescale 1ns/1ps
module tb_freelist_top;
  localparam int D = 32, RW = 7, AW = 4, FW = 4, B = 32, PW = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] alloc_req;
  logic alloc_ok;
  logic [AW-1:0][RW-1:0] alloc_idx;
  logic [FW-1:0] free_vld;
  logic [FW-1:0][RW-1:0] free_idx;
  logic redirect_valid;
  logic [PW-1:0] redirect_head, free_count;

  always #2.5 clk = ~clk;

  freelist_top dut (.clk(clk), .rst_n(rst_n), .alloc_req(alloc_req),
    .alloc_ok(alloc_ok), .alloc_idx(alloc_idx), .free_vld(free_vld),
    .free_idx(free_idx), .redirect_valid(redirect_valid),
    .redirect_head(redirect_head), .free_count(free_count));

  int nchk = 0, nfail = 0;
  int mq[D];
  int mhead, mtail;
  int mpend[$], outlist[$], specl[$];
  bit mcan;
  bit outst[1 << RW];

  task automatic check(input bit ok, input string r, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic bit can_next(input int t, input int h);
    return (t - h) > AW;
  endfunction

  task automatic step(input logic [AW-1:0] req, input logic [FW-1:0] fpat,
                      input bit redir, input int ckpt, input bit spec);
    int nf[$];
    int p, e, v;
    logic [FW-1:0] fv;
    @(negedge clk);
    fv = '0;
    for (int k = 0; k < FW; k++) begin
      if (fpat[k] && outlist.size() > 0) begin
        int s;
        s = int'($urandom % outlist.size());
        v = outlist[s];
        outlist.delete(s);
        fv[k] = 1'b1;
        free_idx[k] = RW'(v);
        outst[v] = 1'b0;
        nf.push_back(v);
      end else free_idx[k] = RW'($urandom);
    end
    alloc_req = req; free_vld = fv;
    redirect_valid = redir; redirect_head = PW'(ckpt % 64);
    #1;
    e = mtail + mpend.size() - mhead;
    check(int'(free_count) == e, "R6", int'(free_count), e);
    check(int'(free_count) <= D, "R8", int'(free_count), D);
    check(alloc_ok == (mcan && !redir), redir ? "R7" : "R4", int'(alloc_ok), int'(mcan && !redir));
    if (alloc_ok) begin
      p = 0;
      for (int k = 0; k < AW; k++) if (req[k]) begin
        e = mq[(mhead + p) % D];
        check(int'(alloc_idx[k]) == e, (mhead >= D) ? "R5" : ((p == 0) ? "R3" : "R2"),
              int'(alloc_idx[k]), e);
        check(!outst[alloc_idx[k]], "R8", int'(alloc_idx[k]), -1);
        p++;
      end
    end
    @(posedge clk);
    if (mcan && !redir)
      for (int k = 0; k < AW; k++) if (req[k]) begin
        v = mq[mhead % D]; mhead++; outst[v] = 1'b1;
        if (spec) specl.push_back(v); else outlist.push_back(v);
      end
    if (redir) begin
      foreach (specl[i]) outst[specl[i]] = 1'b0;
      specl.delete();
      mhead = ckpt;
    end
    foreach (mpend[i]) begin mq[mtail % D] = mpend[i]; mtail++; end
    mpend = nf;
    mcan = can_next(mtail, mhead);
  endtask

  task automatic episode(input logic [FW-1:0] fpat_at_redirect);
    int ck;
    ck = mhead;
    for (int i = 0; i < 3; i++) step(AW'($urandom), FW'($urandom), 1'b0, 0, 1'b1);
    step('1, fpat_at_redirect, 1'b1, ck, 1'b0);
  endtask

  initial begin
    #1000000;
    nchk++; nfail++;
    $display("FAIL R3 watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < D; i++) mq[i] = B + i;
    mhead = 0; mtail = D; mcan = 1'b1;
    rst_n = 1'b0; alloc_req = '0; free_vld = '0; free_idx = '0;
    redirect_valid = 1'b0; redirect_head = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    alloc_req = '1;
    #1;
    // R1: reset state
    check(int'(free_count) == D, "R1", int'(free_count), D);
    check(alloc_ok == 1'b1, "R1", int'(alloc_ok), 1);
    for (int k = 0; k < AW; k++)
      check(int'(alloc_idx[k]) == B + k, "R1", int'(alloc_idx[k]), B + k);
    alloc_req = '0;
    // R2: sparse lanes take consecutive entries in lane order
    step(4'b1010, '0, 1'b0, 0, 1'b0);
    step(4'b0001, '0, 1'b0, 0, 1'b0);
    // R4: drain until allocation is refused
    repeat (10) step('1, '0, 1'b0, 0, 1'b0);
    // R5/R6: release into a nearly empty list, then reuse
    step('0, 4'b1111, 1'b0, 0, 1'b0);
    step('0, 4'b0101, 1'b0, 0, 1'b0);
    repeat (4) step('1, 4'b1011, 1'b0, 0, 1'b0);
    // R7: redirect in the same cycle as releases
    episode(4'b0011);
    step('1, '0, 1'b0, 0, 1'b0);
    for (int n = 0; n < 3000; n++) begin
      if (n % 40 == 39) episode(FW'($urandom));
      else step(AW'($urandom), FW'($urandom), 1'b0, 0, 1'b0);
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule